// File: doc/BRIEF.md
# Edge-Capturing General-Purpose Pin Bank

This block controls 32 general-purpose pins behind a small register bus. Each pin has its own bit, and pin n uses bit n of every register. Software makes a pin an output or an input through a direction register. It raises output levels with a write-one-to-set register and lowers them with a write-one-to-clear register. At any time it can read the level of every pin. The output latch and the pin levels are never overwritten as a whole word.

Each pin input passes through a synchronizer before the block uses it. A per-pin rising-edge enable and a per-pin falling-edge enable select which transitions are captured. A captured transition sets a sticky status bit, which stays set until software writes a one to it. The OR of all status bits drives one interrupt line. The usual service routine reads the status register, handles the pins it reports, and writes the same value back.

Top module: `gpio_edge_bank`

## Requirements
- R1: A read of offset 0x00 returns the synchronized level of all pins, whatever their direction. A change on `pin_i` first appears there after two rising clock edges.
- R2: A write to offset 0x18 drives high each `pin_o` bit whose data bit is 1. Bits written as 0 keep their current level.
- R3: A write to offset 0x24 drives low each `pin_o` bit whose data bit is 1. Bits written as 0 keep their current level.
- R4: Offset 0x0C is a read/write direction register that drives `pin_oe_o`. A 1 makes the pin an output.
- R5: Offset 0x30 holds the per-pin rising enables. A synchronized 0-to-1 transition on an enabled pin sets its status bit at offset 0x48, three clock edges after `pin_i` changes.
- R6: Offset 0x3C holds the per-pin falling enables. A 1-to-0 transition on an enabled pin sets its status bit. With both enables set, either edge is captured.
- R7: Writing 1 to a bit of offset 0x48 clears that status bit. Writing 0 leaves it unchanged. Status bits are otherwise sticky.
- R8: `irq_o` is high exactly when at least one status bit is set.
- R9: If a captured edge and a clearing write to the same status bit take effect at the same clock edge, the bit ends up set.
- R10: After reset every register is zero: all pins are inputs, the output latch is low, both edge enables are off and the status is clear.
- R11: Reads of offsets 0x18 and 0x24 return zero. Every other unmapped offset reads as zero and ignores writes. `rdata_o` is zero while `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte offset of the register access |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid in the same cycle as `rd_i` |
| pin_i | input | 32 | Pin levels from the pads, asynchronous |
| pin_o | output | 32 | Output latch levels |
| pin_oe_o | output | 32 | Output enables, 1 = drive |
| irq_o | output | 1 | OR of all edge status bits |

## Verification
The two actions that can fall on the same clock edge are a captured transition and a software clear of the same status bit. The bench lines them up by changing a pin and then issuing the clearing write exactly two cycles later, so that both reach the status flop together. It then reads the status register and expects the bit to be set. A cycle-accurate behavioural model of the bank is compared against the design on every cycle. Directed reads also check fixed expected values, both at the collision and around it, including a plain clear with no edge pending.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_LEVEL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_SET   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_RISE  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_FALL  = 8'h3C;
  localparam logic [ADDR_W-1:0] OFF_EDGE  = 8'h48;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_LEVEL, SEL_DIR, SEL_SET, SEL_CLR, SEL_RISE, SEL_FALL, SEL_EDGE
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFF_LEVEL: s = SEL_LEVEL;
      OFF_DIR:   s = SEL_DIR;
      OFF_SET:   s = SEL_SET;
      OFF_CLR:   s = SEL_CLR;
      OFF_RISE:  s = SEL_RISE;
      OFF_FALL:  s = SEL_FALL;
      OFF_EDGE:  s = SEL_EDGE;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
  import gpio_edge_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] out_q_o,
  output logic [W-1:0] dir_q_o,
  output logic [W-1:0] rise_en_o,
  output logic [W-1:0] fall_en_o
);
  logic [W-1:0] out_q, dir_q, rise_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (wr_i) begin
      case (sel_i)
        SEL_SET:  out_q  <= out_q | wdata_i;
        SEL_CLR:  out_q  <= out_q & ~wdata_i;
        SEL_DIR:  dir_q  <= wdata_i;
        SEL_RISE: rise_q <= wdata_i;
        SEL_FALL: fall_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign out_q_o   = out_q;
  assign dir_q_o   = dir_q;
  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  for (genvar i = 0; i < int'(W); i++) begin : g_pin
    logic prev_q, st_q, hit;

    assign hit = (lvl_i[i] & ~prev_q & rise_en_i[i]) |
                 (~lvl_i[i] & prev_q & fall_en_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        st_q   <= 1'b0;
      end else begin
        prev_q <= lvl_i[i];
        // a new edge overrides a concurrent clear
        st_q   <= hit | (st_q & ~clr_i[i]);
      end
    end

    assign status_o[i] = st_q;
  end

  assign irq_o = |status_o;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [NPINS-1:0]  rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  reg_sel_e         sel;
  logic [NPINS-1:0] lvl, out_q, dir_q, rise_en, fall_en, clr_mask, status;

  assign sel      = decode_sel(addr_i);
  assign clr_mask = (wr_i && sel == SEL_EDGE) ? wdata_i : '0;

  gpio_edge_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (lvl)
  );

  gpio_edge_regs #(.W(NPINS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .sel_i     (sel),
    .wdata_i   (wdata_i),
    .out_q_o   (out_q),
    .dir_q_o   (dir_q),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en)
  );

  gpio_edge_detect #(.W(NPINS)) u_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (lvl),
    .rise_en_i (rise_en),
    .fall_en_i (fall_en),
    .clr_i     (clr_mask),
    .status_o  (status),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (sel)
        SEL_LEVEL: rdata_o = lvl;
        SEL_DIR:   rdata_o = dir_q;
        SEL_RISE:  rdata_o = rise_en;
        SEL_FALL:  rdata_o = fall_en;
        SEL_EDGE:  rdata_o = status;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NPINS-1:0]  wdata_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [NPINS-1:0]  rdata_o,
  input logic [NPINS-1:0]  pin_o,
  input logic [NPINS-1:0]  pin_oe_o,
  input logic              irq_o
);
  logic unmapped;
  assign unmapped = !(addr_i inside {OFF_LEVEL, OFF_DIR, OFF_SET, OFF_CLR,
                                     OFF_RISE, OFF_FALL, OFF_EDGE});

  a_r2_set_drives_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_SET) |=> ((pin_o & $past(wdata_i)) == $past(wdata_i)));

  a_r3_clr_drives_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFF_CLR) |=> ((pin_o & $past(wdata_i)) == '0));

  a_r4_dir_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFF_DIR) |-> (rdata_o == pin_oe_o));

  a_r7_status_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(wr_i && addr_i == OFF_EDGE)) |=> irq_o);

  a_r8_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFF_EDGE && rdata_o == '0) |-> !irq_o);

  a_r11_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && unmapped) |=> ($stable(pin_o) && $stable(pin_oe_o)));

  a_r11_strobe_regs_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i == OFF_SET || addr_i == OFF_CLR)) |-> (rdata_o == '0));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .rdata_o  (rdata_o),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o),
  .irq_o    (irq_o)
);

// File: tb/gpio_edge_bank_bench.sv
`timescale 1ns/1ps
module gpio_edge_bank_bench;
  localparam int NP = 32;
  localparam logic [7:0] A_LVL = 8'h00, A_DIR = 8'h0C, A_SET = 8'h18, A_CLR = 8'h24,
                         A_RISE = 8'h30, A_FALL = 8'h3C, A_EDGE = 8'h48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    addr = '0;
  logic [NP-1:0] wdata = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [NP-1:0] rdata, pin_in = '0, pin_out, pin_oe;
  logic          irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_edge_bank u_gpio_edge_bank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .rd_i(rd), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // behavioural reference: hist holds {previous, synchronized, first stage}
  logic [NP-1:0] hist[$];
  logic [NP-1:0] m_dir, m_out, m_ren, m_fen, m_st;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{NP'(0), NP'(0), NP'(0)};
      m_dir = '0; m_out = '0; m_ren = '0; m_fen = '0; m_st = '0;
    end else begin
      logic [NP-1:0] rise, fall, clr;
      rise = hist[1] & ~hist[0];
      fall = ~hist[1] & hist[0];
      clr  = (wr && addr == A_EDGE) ? wdata : '0;
      m_st = (m_st & ~clr) | (rise & m_ren) | (fall & m_fen);
      if (wr) begin
        case (addr)
          A_DIR:  m_dir = wdata;
          A_SET:  m_out = m_out | wdata;
          A_CLR:  m_out = m_out & ~wdata;
          A_RISE: m_ren = wdata;
          A_FALL: m_fen = wdata;
          default: ;
        endcase
      end
      hist.push_back(pin_in);
      void'(hist.pop_front());
    end
  end

  function automatic logic [NP-1:0] model_read(input logic [7:0] a);
    case (a)
      A_LVL:  return hist[1];
      A_DIR:  return m_dir;
      A_RISE: return m_ren;
      A_FALL: return m_fen;
      A_EDGE: return m_st;
      default: return '0;
    endcase
  endfunction

  function automatic string read_tag(input logic [7:0] a);
    case (a)
      A_LVL:  return "R1";
      A_DIR:  return "R4";
      A_RISE: return "R5";
      A_FALL: return "R6";
      A_EDGE: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R2/R3 pin_o", pin_out, m_out);
      check("R4 pin_oe_o", pin_oe, m_dir);
      check("R8 irq_o", NP'(irq), NP'(|m_st));
      check(read_tag(addr), rdata, rd ? model_read(addr) : '0);
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [NP-1:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #2;
    check(tag, rdata, exp);
    rd = 1'b0;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    wait_neg(3);
    rst_n = 1'b1;

    // R10 reset state
    chk_rd(A_LVL, '0, "R10 level");
    chk_rd(A_DIR, '0, "R10 dir");
    chk_rd(A_RISE, '0, "R10 rise");
    chk_rd(A_FALL, '0, "R10 fall");
    chk_rd(A_EDGE, '0, "R10 status");
    #1;
    check("R10 pin_o", pin_out, '0);
    check("R10 pin_oe_o", pin_oe, '0);
    check("R10 irq", NP'(irq), '0);

    // R2 / R3 set and clear
    bus_wr(A_SET, 32'hA5A5_0000); #1;
    check("R2 set", pin_out, 32'hA5A5_0000);
    bus_wr(A_SET, 32'h0000_00FF); #1;
    check("R2 set keeps zeros", pin_out, 32'hA5A5_00FF);
    bus_wr(A_CLR, 32'hA000_0F0F); #1;
    check("R3 clear", pin_out, 32'h05A5_00F0);

    // R4 direction
    bus_wr(A_DIR, 32'hFFFF_0000);
    chk_rd(A_DIR, 32'hFFFF_0000, "R4 dir readback");
    check("R4 pin_oe", pin_oe, 32'hFFFF_0000);

    // R1 level read with two-edge latency, both directions
    @(negedge clk); pin_in = 32'h1234_5678;
    chk_rd(A_LVL, '0, "R1 level before sync");
    chk_rd(A_LVL, 32'h1234_5678, "R1 level after sync");

    // R5 rising capture on enabled pins only
    bus_wr(A_RISE, 32'h0000_0101);
    @(negedge clk); pin_in = 32'h1234_577B;
    wait_neg(2);
    chk_rd(A_EDGE, 32'h0000_0101, "R5 rising capture");
    check("R8 irq high", NP'(irq), NP'(1));

    // R7 partial clear, then write-back clear
    bus_wr(A_EDGE, 32'h0000_0100);
    chk_rd(A_EDGE, 32'h0000_0001, "R7 partial clear");
    bus_wr(A_EDGE, 32'h0000_0001);
    chk_rd(A_EDGE, '0, "R7 write-back clear");
    check("R8 irq low", NP'(irq), '0);

    // R6 falling capture and both-edge mode on bit 0
    bus_wr(A_FALL, 32'h0000_0011);
    @(negedge clk); pin_in = 32'h1234_576A;
    wait_neg(3);
    chk_rd(A_EDGE, 32'h0000_0011, "R6 falling capture");
    bus_wr(A_EDGE, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = 32'h1234_576B;
    wait_neg(3);
    chk_rd(A_EDGE, 32'h0000_0001, "R6 both edges rising");

    // R9 edge and clear at the same edge, bit already set
    @(negedge clk); pin_in = 32'h1234_576A;
    @(negedge clk);
    @(negedge clk); addr = A_EDGE; wdata = 32'h0000_0001; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk_rd(A_EDGE, 32'h0000_0001, "R9 edge wins over clear");
    bus_wr(A_EDGE, 32'h0000_0001);
    chk_rd(A_EDGE, '0, "R9 clear without edge");

    // R9 again with the bit clear beforehand
    @(negedge clk); pin_in = 32'h1234_576B;
    @(negedge clk);
    @(negedge clk); addr = A_EDGE; wdata = 32'h0000_0001; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk_rd(A_EDGE, 32'h0000_0001, "R9 edge wins from clear");
    bus_wr(A_EDGE, 32'h0000_0001);

    // R11 unmapped offsets and write-only registers
    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_wr(8'h50, 32'hFFFF_FFFF);
    bus_wr(8'h0D, 32'h0000_0000);
    #1;
    check("R11 pin_o untouched", pin_out, 32'h05A5_00F0);
    check("R11 pin_oe untouched", pin_oe, 32'hFFFF_0000);
    chk_rd(8'h04, '0, "R11 unmapped read");
    chk_rd(A_SET, '0, "R11 set reads zero");
    chk_rd(A_CLR, '0, "R11 clear reads zero");
    chk_rd(A_EDGE, '0, "R11 status untouched");
    chk_rd(A_RISE, 32'h0000_0101, "R11 rise untouched");

    wait_neg(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule